// File: doc/BRIEF.md
# Triple-Mode Digital Phase Comparator

This block takes two asynchronous square-wave inputs, a reference signal and a feedback signal that usually comes from a divided oscillator output. It computes three phase-error outputs in parallel from the same pair. The first is an exclusive-OR detector. Its average output tracks the phase difference, and it reaches its full range only when both inputs run at 50% duty. The second is a rising-edge phase-frequency detector. Its pull-up and pull-down drive enables rest at the high-impedance code 00, and it has a lock flag that is HIGH whenever neither drive is active. The third is a rising-edge set-reset detector. Its output duty is 50% when the inputs are 180 degrees apart.

Each input first passes through a synchroniser chain (`SYNC_STAGES` flops, default 2) and then an edge detector. All detector state is held in registers on the system clock, and a synchronous active-high reset clears that state. The oscillator, the loop filter and any analog buffering sit outside this block.

The phase-frequency detector is a state machine with three states:
- `PFD_IDLE`: high-impedance, lock HIGH.
  - A lone reference rise moves it to `PFD_UP`.
  - A lone feedback rise moves it to `PFD_DOWN`.
  - Simultaneous rises keep it in `PFD_IDLE`.
- `PFD_UP`: pull-up active.
  - A feedback rise returns it to `PFD_IDLE`.
  - Further reference rises keep it in `PFD_UP`.
- `PFD_DOWN`: pull-down active.
  - A reference rise returns it to `PFD_IDLE`.
  - Further feedback rises keep it in `PFD_DOWN`.

The set-reset detector has two states, `SR_LOW` and `SR_HIGH`:
- A lone reference rise moves it to `SR_HIGH`.
- A lone feedback rise moves it to `SR_LOW`.
- Simultaneous rises hold the current state.

Top module: `tri_phase_comparator`

## Requirements
- R1: Each input is synchronised before use. With the default 2 stages, an input change made before clock edge k reaches the outputs at edge k+2, the third rising edge counting edge k.
- R2: While `rst` is HIGH, at every clock edge, the outputs go to `xor_out`=0, `up_en`=0, `down_en`=0, `lock_out`=1 and `sr_out`=0. The synchroniser flops are cleared at the same time.
- R3: `xor_out` equals the exclusive-OR of the two synchronised input levels.
- R4: From `PFD_IDLE`, a lone reference rise sets `up_en`=1, and a lone feedback rise sets `down_en`=1.
- R5: In `PFD_UP`, a feedback rise clears both enables, and further reference rises leave `up_en` at 1. In `PFD_DOWN`, a reference rise clears both enables, and further feedback rises leave `down_en` at 1.
- R6: Rises on both inputs in the same cycle while in `PFD_IDLE` leave both enables at 0. `up_en` and `down_en` are never 1 together.
- R7: The detector output code is {`up_en`,`down_en`}, where 00 is high-impedance, 10 is pull-up and 01 is pull-down. `lock_out` is 1 exactly when the code is 00.
- R8: A lone reference rise sets `sr_out`=1, and a lone feedback rise sets `sr_out`=0.
- R9: Rises on both inputs in the same cycle leave `sr_out` unchanged.
- R10: Falling edges and duty factor have no effect on `up_en`, `down_en` or `sr_out`.
- R11: With the reference input idle and the feedback input toggling, the outputs settle at `down_en`=1, `lock_out`=0 and `sr_out`=0, which drives the oscillator toward its lowest frequency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous reference signal |
| cmp_in | input | 1 | Asynchronous feedback (comparator) signal |
| xor_out | output | 1 | Exclusive-OR detector output |
| up_en | output | 1 | Phase-frequency detector pull-up enable |
| down_en | output | 1 | Phase-frequency detector pull-down enable |
| lock_out | output | 1 | HIGH while both drives are off (lock indication) |
| sr_out | output | 1 | Set-reset detector output |

## Verification
The bench drives several kinds of input pattern, and each one separates a different part of the behaviour:
- A single reference edge from idle pins down the pipeline latency.
- A falling edge held for several cycles shows that only rising edges matter.
- Rises landing in the same cycle separate the cancel path of the phase-frequency detector from the hold path of the set-reset detector.
- A feedback-only toggle train confirms the drift toward the lowest frequency.
- An equal-frequency train with a fixed lead exercises the phase-proportional pull-up pulses.
- Long random runs, with random hold lengths on each input, mix frequency and duty mismatches, and a per-cycle model checks every output.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_UP   = 2'd1,
        PFD_DOWN = 2'd2
    } pfd_state_e;

    typedef enum logic {
        SR_LOW  = 1'b0,
        SR_HIGH = 1'b1
    } sr_state_e;

endpackage

// File: rtl/tpc_sync_edge.sv
module tpc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[LAST-1:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[LAST];
    end

    assign level = chain_q[LAST];
    assign rise  = chain_q[LAST] & ~prev_q;

    AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R1

endmodule

// File: rtl/tpc_pfd_core.sv
module tpc_pfd_core
    import tpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sig_rise,
    input  logic cmp_rise,
    output logic up_en,
    output logic down_en,
    output logic lock_out
);
    pfd_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PFD_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PFD_IDLE: begin
                if (sig_rise && !cmp_rise)      state_d = PFD_UP;
                else if (cmp_rise && !sig_rise) state_d = PFD_DOWN;
            end
            PFD_UP: begin
                if (cmp_rise) state_d = PFD_IDLE;
            end
            PFD_DOWN: begin
                if (sig_rise) state_d = PFD_IDLE;
            end
            default: state_d = PFD_IDLE;
        endcase
    end

    always_comb begin
        up_en    = 1'b0;
        down_en  = 1'b0;
        lock_out = 1'b0;
        unique case (state_q)
            PFD_IDLE: lock_out = 1'b1;
            PFD_UP:   up_en    = 1'b1;
            PFD_DOWN: down_en  = 1'b1;
            default:  lock_out = 1'b1;
        endcase
    end

    AST_UP_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == PFD_IDLE && sig_rise && !cmp_rise) |=> (state_q == PFD_UP)); // R4
    AST_DOWN_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == PFD_IDLE && cmp_rise && !sig_rise) |=> (state_q == PFD_DOWN)); // R4
    AST_UP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (state_q == PFD_UP && cmp_rise) |=> (state_q == PFD_IDLE)); // R5
    AST_DOWN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (state_q == PFD_DOWN && sig_rise) |=> (state_q == PFD_IDLE)); // R5
    AST_BOTH_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (state_q == PFD_IDLE && sig_rise && cmp_rise) |=> (state_q == PFD_IDLE)); // R6

endmodule

// File: rtl/tpc_sr_core.sv
module tpc_sr_core
    import tpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sig_rise,
    input  logic cmp_rise,
    output logic sr_out
);
    sr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SR_LOW;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_LOW:  if (sig_rise && !cmp_rise) state_d = SR_HIGH;
            SR_HIGH: if (cmp_rise && !sig_rise) state_d = SR_LOW;
            default: state_d = SR_LOW;
        endcase
    end

    always_comb begin
        sr_out = (state_q == SR_HIGH);
    end

    AST_SR_SET: assert property (@(posedge clk) disable iff (rst)
        (sig_rise && !cmp_rise) |=> sr_out); // R8
    AST_SR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmp_rise && !sig_rise) |=> !sr_out); // R8
    AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sig_rise && cmp_rise) |=> $stable(sr_out)); // R9

endmodule

// File: rtl/tri_phase_comparator.sv
module tri_phase_comparator #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    input  logic cmp_in,
    output logic xor_out,
    output logic up_en,
    output logic down_en,
    output logic lock_out,
    output logic sr_out
);
    logic sig_lvl, sig_rise;
    logic cmp_lvl, cmp_rise;
    logic xor_q;

    tpc_sync_edge #(.STAGES(SYNC_STAGES)) u_sig_sync (
        .clk(clk), .rst(rst), .async_in(sig_in), .level(sig_lvl), .rise(sig_rise)
    );

    tpc_sync_edge #(.STAGES(SYNC_STAGES)) u_cmp_sync (
        .clk(clk), .rst(rst), .async_in(cmp_in), .level(cmp_lvl), .rise(cmp_rise)
    );

    always_ff @(posedge clk) begin
        if (rst) xor_q <= 1'b0;
        else     xor_q <= sig_lvl ^ cmp_lvl;
    end
    assign xor_out = xor_q;

    tpc_pfd_core u_pfd (
        .clk(clk), .rst(rst), .sig_rise(sig_rise), .cmp_rise(cmp_rise),
        .up_en(up_en), .down_en(down_en), .lock_out(lock_out)
    );

    tpc_sr_core u_sr (
        .clk(clk), .rst(rst), .sig_rise(sig_rise), .cmp_rise(cmp_rise),
        .sr_out(sr_out)
    );

    AST_DRIVE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(up_en && down_en)); // R6
    AST_LOCK_MATCHES_CODE: assert property (@(posedge clk) disable iff (rst)
        lock_out == (!up_en && !down_en)); // R7

endmodule

// File: tb/tri_phase_comparator_tb.sv
`timescale 1ns/1ps
module tri_phase_comparator_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig = 1'b0;
    logic cmp = 1'b0;
    logic xor_out, up_en, down_en, lock_out, sr_out;

    int checks = 0;
    int fails  = 0;
    bit chk_en = 1'b0;

    always #10 clk = ~clk;

    tri_phase_comparator #(.SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .sig_in(sig), .cmp_in(cmp),
        .xor_out(xor_out), .up_en(up_en), .down_en(down_en),
        .lock_out(lock_out), .sr_out(sr_out)
    );

    // Expected-value model built from the requirements (0 idle, 1 up, 2 down)
    function automatic int pfd_next(input int st, input logic sr, input logic cr);
        if (st == 0) begin
            if (sr && !cr) return 1;
            if (cr && !sr) return 2;
            return 0;
        end
        if (st == 1) return cr ? 0 : 1;
        return sr ? 0 : 2;
    endfunction

    function automatic logic sr_next(input logic cur, input logic sr, input logic cr);
        if (sr && !cr) return 1'b1;
        if (cr && !sr) return 1'b0;
        return cur;
    endfunction

    logic ms1, ms2, ms3, mc1, mc2, mc3, mxor, msr;
    int   mpfd;

    always @(posedge clk) begin
        if (rst) begin
            ms1 <= 0; ms2 <= 0; ms3 <= 0; mc1 <= 0; mc2 <= 0; mc3 <= 0;
            mxor <= 0; msr <= 0; mpfd <= 0;
        end else begin
            ms1 <= sig; ms2 <= ms1; ms3 <= ms2;
            mc1 <= cmp; mc2 <= mc1; mc3 <= mc2;
            mxor <= ms2 ^ mc2;
            mpfd <= pfd_next(mpfd, ms2 & ~ms3, mc2 & ~mc3);
            msr  <= sr_next(msr, ms2 & ~ms3, mc2 & ~mc3);
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !rst) begin
            chk(xor_out, mxor, "R3 xor_out");
            chk(up_en, (mpfd == 1), "R4/R5 up_en");
            chk(down_en, (mpfd == 2), "R4/R5 down_en");
            chk(lock_out, (mpfd == 0), "R7 lock_out");
            chk(sr_out, msr, "R8 sr_out");
            chk(up_en & down_en, 1'b0, "R6 exclusive drives");
        end
    end

    task automatic drive(input logic s, input logic c);
        #1; sig = s; cmp = c;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_reset_state(input string tag);
        chk(xor_out, 1'b0, tag);
        chk(up_en, 1'b0, tag);
        chk(down_en, 1'b0, tag);
        chk(lock_out, 1'b1, tag);
        chk(sr_out, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait_neg(3);
        check_reset_state("R2 reset state");
        #1 rst = 1'b0;
        chk_en = 1'b1;
        wait_neg(3);

        // R1: latency of a lone reference rise; R4 up drive; R8 set
        drive(1, 0);
        wait_neg(2);
        chk(up_en, 1'b0, "R1 up_en before third edge");
        wait_neg(1);
        chk(up_en, 1'b1, "R1 up_en at third edge");
        chk(sr_out, 1'b1, "R8 sr_out set by reference rise");

        // R10: falling reference edge changes nothing
        drive(0, 0);
        wait_neg(4);
        chk(up_en, 1'b1, "R10 up_en after falling edge");
        chk(sr_out, 1'b1, "R10 sr_out after falling edge");

        // R5: feedback rise clears pull-up; R8 clear; R7 lock
        drive(0, 1);
        wait_neg(3);
        chk(up_en, 1'b0, "R5 up_en cleared");
        chk(down_en, 1'b0, "R5 down_en stays off");
        chk(lock_out, 1'b1, "R7 lock_out with code 00");
        chk(sr_out, 1'b0, "R8 sr_out cleared by feedback rise");

        // R6 / R9: simultaneous rises from idle, sr low
        drive(0, 0);
        wait_neg(3);
        drive(1, 1);
        wait_neg(3);
        chk(up_en, 1'b0, "R6 up_en after simultaneous rises");
        chk(down_en, 1'b0, "R6 down_en after simultaneous rises");
        chk(sr_out, 1'b0, "R9 sr_out holds low");

        // R9 with sr high; R5 from pull-up with simultaneous rises
        drive(0, 0);
        wait_neg(3);
        drive(1, 0);
        wait_neg(3);
        drive(0, 0);
        wait_neg(3);
        drive(1, 1);
        wait_neg(3);
        chk(sr_out, 1'b1, "R9 sr_out holds high");
        chk(up_en, 1'b0, "R5 up_en cleared by coincident feedback rise");

        // R11: idle reference, toggling feedback
        drive(0, 0);
        wait_neg(3);
        for (int i = 0; i < 20; i++) begin
            drive(0, 1);
            wait_neg(2);
            drive(0, 0);
            wait_neg(2);
        end
        wait_neg(2);
        chk(down_en, 1'b1, "R11 down_en settles");
        chk(lock_out, 1'b0, "R11 lock_out low");
        chk(sr_out, 1'b0, "R11 sr_out low");

        // Equal frequency, reference leading by two cycles
        for (int p = 0; p < 10; p++) begin
            drive(1, 0);
            wait_neg(2);
            drive(1, 1);
            wait_neg(2);
            drive(0, 1);
            wait_neg(2);
            drive(0, 0);
            wait_neg(2);
        end

        // R2: reset mid-run with inputs high
        drive(1, 1);
        rst = 1'b1;
        wait_neg(1);
        check_reset_state("R2 reset mid-run");
        drive(0, 0);
        rst = 1'b0;
        wait_neg(3);

        // Random hold lengths on both inputs
        begin
            int unsigned seed;
            logic s_r, c_r;
            int hold;
            seed = 32'd1234;
            s_r = 0;
            c_r = 0;
            void'($urandom(seed));
            for (int i = 0; i < 3000; i++) begin
                if (($urandom % 3) != 0) s_r = ~s_r;
                if (($urandom % 3) != 0) c_r = ~c_r;
                hold = 1 + int'($urandom % 6);
                drive(s_r, c_r);
                wait_neg(hold);
            end
        end

        drive(0, 0);
        wait_neg(4);
        chk_en = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule